// File: doc/BRIEF.md
# Unaligned Word Load/Store Merge Unit

This unit runs the four partial-word memory operations of a little-endian 32-bit core: load-left, load-right, store-left and store-right. Each operation takes an opcode, a base register value, a sign-extended immediate and the current value of the target register. From these the unit forms an effective address and a byte offset. It then merges byte lanes between a memory word and a register word, using masks that the offset selects.

The unit reaches memory through one word-aligned request channel with a valid/ready handshake, plus a separate read-response strobe. A load reads the aligned word once and merges it into the register value that was supplied with the operation. The result goes out on a delayed write-back port. A store reads the aligned word, merges the register bytes into it, and writes the new word back to the same address. While an operation is in flight the unit raises `busy` and ignores any new operation. Every operation finishes with a single-cycle `done` strobe.

Top module: `unaligned_merge_unit`

## Requirements
- R1: Every memory request carries the address (op_base + sign-extended op_imm) with bits [1:0] cleared. The offset k is bits [1:0] of that sum, and the shift is s = 8*k.
- R2: op_kind 2'b00 (load-left) writes back (old & (0x00FFFFFF >> s)) | (mem << (24 - s)). In byte terms, register byte i takes memory byte i-(3-k) when i >= 3-k, and otherwise keeps old byte i.
- R3: op_kind 2'b01 (load-right) writes back (old & (0xFFFFFF00 << (24 - s))) | (mem >> s). In byte terms, register byte i takes memory byte i+k when i <= 3-k, and otherwise keeps old byte i.
- R4: op_kind 2'b10 (store-left) writes (mem & (0xFFFFFF00 << s)) | (reg >> (24 - s)). In byte terms, memory byte i takes register byte i+3-k when i <= k, and otherwise keeps memory byte i.
- R5: op_kind 2'b11 (store-right) writes (mem & (0x00FFFFFF >> (24 - s))) | (reg << s). In byte terms, memory byte i takes register byte i-k when i >= k, and otherwise keeps memory byte i.
- R6: The register value used in a merge is the op_rt_val captured when the operation is accepted. Later changes on the operation inputs do not affect it.
- R7: A load issues exactly one read and no write. A store issues exactly one read and then exactly one write, to the same aligned address. The write is issued only after the read response has arrived.
- R8: A request, once valid, holds its valid, address and write flag stable until it is accepted by mem_req_ready.
- R9: busy is high from the cycle after an operation is accepted until the cycle after done. An op_valid seen while busy is high is ignored and starts nothing.
- R10: done is high for exactly one cycle per operation. For a load, wb_valid, wb_idx (the captured op_rt_idx) and wb_data are presented in that same cycle. For a store, wb_valid stays low.
- R11: The full-replacement corners hold. Load-left with k=3 and load-right with k=0 return the whole memory word. Store-left with k=3 and store-right with k=0 write the whole register word.
- R12: During and right after reset, busy, mem_req_valid, done and wb_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | New operation offered |
| op_kind | input | 2 | 00 load-left, 01 load-right, 10 store-left, 11 store-right |
| op_base | input | 32 | Base register value |
| op_imm | input | IMM_W | Immediate, sign-extended inside |
| op_rt_idx | input | RIDX_W | Target register index |
| op_rt_val | input | 32 | Committed value of the target register |
| busy | output | 1 | Operation in flight, new offers ignored |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word-aligned request address |
| mem_req_wdata | output | 32 | Merged store word |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle completion strobe |
| wb_valid | output | 1 | Delayed write-back valid (loads only) |
| wb_idx | output | RIDX_W | Write-back register index |
| wb_data | output | 32 | Merged load result |

## Verification
The completion strobe and a fresh operation offer can fall in the same cycle. So can a held request and a change of the operation inputs. To provoke this, the bench keeps op_valid high with altered kind, base and register value for the whole time the unit is busy, including the done cycle. It also stalls mem_req_ready and delays responses by a pseudo-random pattern. The bench then counts the reads and writes each operation issued, compares every address and merged word with byte-wise expectations, and confirms that done is not repeated and that busy falls only after done.

// File: rtl/umu_pkg.sv
package umu_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned OFS_W  = $clog2(WORD_W / LANE_W);
  localparam int unsigned SH_W   = $clog2(WORD_W);

  typedef enum logic [1:0] {
    K_LDL = 2'd0,
    K_LDR = 2'd1,
    K_STL = 2'd2,
    K_STR = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_WR_REQ,
    S_FIN
  } state_e;

  localparam logic [WORD_W-1:0] LO3_MASK = 32'h00FF_FFFF;
  localparam logic [WORD_W-1:0] HI3_MASK = 32'hFFFF_FF00;
  localparam logic [SH_W-1:0]   TOP_SH   = SH_W'(WORD_W - LANE_W);

  // load-left: upper register lanes come from memory
  function automatic logic [WORD_W-1:0] mrg_ldl(input logic [WORD_W-1:0] old_reg,
                                                input logic [WORD_W-1:0] mem_w,
                                                input logic [SH_W-1:0]   sh);
    return (old_reg & (LO3_MASK >> sh)) | (mem_w << (TOP_SH - sh));
  endfunction

  // load-right: lower register lanes come from memory
  function automatic logic [WORD_W-1:0] mrg_ldr(input logic [WORD_W-1:0] old_reg,
                                                input logic [WORD_W-1:0] mem_w,
                                                input logic [SH_W-1:0]   sh);
    return (old_reg & (HI3_MASK << (TOP_SH - sh))) | (mem_w >> sh);
  endfunction

  // store-left: lower memory lanes come from upper register lanes
  function automatic logic [WORD_W-1:0] mrg_stl(input logic [WORD_W-1:0] reg_w,
                                                input logic [WORD_W-1:0] mem_w,
                                                input logic [SH_W-1:0]   sh);
    return (mem_w & (HI3_MASK << sh)) | (reg_w >> (TOP_SH - sh));
  endfunction

  // store-right: upper memory lanes come from lower register lanes
  function automatic logic [WORD_W-1:0] mrg_str(input logic [WORD_W-1:0] reg_w,
                                                input logic [WORD_W-1:0] mem_w,
                                                input logic [SH_W-1:0]   sh);
    return (mem_w & (LO3_MASK >> (TOP_SH - sh))) | (reg_w << sh);
  endfunction
endpackage

// File: rtl/umu_addr_gen.sv
module umu_addr_gen
  import umu_pkg::*;
#(
  parameter int unsigned IMM_W = 16
) (
  input  logic [WORD_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  output logic [WORD_W-1:0] word_addr,
  output logic [SH_W-1:0]   shamt
);
  localparam int unsigned EXT_W = WORD_W - IMM_W;

  logic [WORD_W-1:0] eff_addr;

  always_comb begin
    eff_addr  = base + {{EXT_W{imm[IMM_W-1]}}, imm};
    word_addr = {eff_addr[WORD_W-1:OFS_W], {OFS_W{1'b0}}};
    shamt     = {eff_addr[OFS_W-1:0], {(SH_W-OFS_W){1'b0}}};
  end
endmodule

// File: rtl/umu_merge.sv
module umu_merge
  import umu_pkg::*;
(
  input  kind_e             kind,
  input  logic [WORD_W-1:0] rt_val,
  input  logic [WORD_W-1:0] mem_word,
  input  logic [SH_W-1:0]   shamt,
  output logic [WORD_W-1:0] merged
);
  always_comb begin
    unique case (kind)
      K_LDL:   merged = mrg_ldl(rt_val, mem_word, shamt);
      K_LDR:   merged = mrg_ldr(rt_val, mem_word, shamt);
      K_STL:   merged = mrg_stl(rt_val, mem_word, shamt);
      default: merged = mrg_str(rt_val, mem_word, shamt);
    endcase
  end
endmodule

// File: rtl/umu_seq.sv
module umu_seq
  import umu_pkg::*;
#(
  parameter int unsigned RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  kind_e             op_kind,
  input  logic [WORD_W-1:0] op_word_addr,
  input  logic [SH_W-1:0]   op_shamt,
  input  logic [RIDX_W-1:0] op_rt_idx,
  input  logic [WORD_W-1:0] op_rt_val,
  output logic              busy,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [WORD_W-1:0] req_addr,
  output logic [WORD_W-1:0] req_wdata,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] merged_in,
  output kind_e             cur_kind,
  output logic [SH_W-1:0]   cur_shamt,
  output logic [WORD_W-1:0] cur_rt_val,
  output logic              done,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [WORD_W-1:0] wb_data,
  output logic              op_take,
  output logic              wr_fire
);
  state_e            st;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic [RIDX_W-1:0] idx_q;
  logic              rd_fire;
  logic              rsp_take;

  assign op_take  = op_valid && (st == S_IDLE);
  assign rd_fire  = (st == S_RD_REQ) && req_ready;
  assign rsp_take = (st == S_RD_WAIT) && rsp_valid;
  assign wr_fire  = (st == S_WR_REQ) && req_ready;

  assign busy      = (st != S_IDLE);
  assign req_valid = (st == S_RD_REQ) || (st == S_WR_REQ);
  assign req_write = (st == S_WR_REQ);
  assign req_addr  = addr_q;
  assign req_wdata = data_q;
  assign done      = (st == S_FIN);
  assign wb_valid  = done && !cur_kind[1];
  assign wb_idx    = idx_q;
  assign wb_data   = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      addr_q     <= '0;
      data_q     <= '0;
      idx_q      <= '0;
      cur_kind   <= K_LDL;
      cur_shamt  <= '0;
      cur_rt_val <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (op_take) begin
          cur_kind   <= op_kind;
          cur_shamt  <= op_shamt;
          cur_rt_val <= op_rt_val;
          addr_q     <= op_word_addr;
          idx_q      <= op_rt_idx;
          st         <= S_RD_REQ;
        end
        S_RD_REQ:  if (rd_fire) st <= S_RD_WAIT;
        S_RD_WAIT: if (rsp_take) begin
          data_q <= merged_in;
          st     <= cur_kind[1] ? S_WR_REQ : S_FIN;
        end
        S_WR_REQ:  if (wr_fire) st <= S_FIN;
        default:   st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/unaligned_merge_unit.sv
module unaligned_merge_unit
  import umu_pkg::*;
#(
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [31:0]       op_base,
  input  logic [IMM_W-1:0]  op_imm,
  input  logic [RIDX_W-1:0] op_rt_idx,
  input  logic [31:0]       op_rt_val,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [31:0]       mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              done,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [31:0]       wb_data
);
  logic [WORD_W-1:0] op_word_addr;
  logic [SH_W-1:0]   op_shamt;
  kind_e             cur_kind;
  logic [SH_W-1:0]   cur_shamt;
  logic [WORD_W-1:0] cur_rt_val;
  logic [WORD_W-1:0] merged;
  logic              op_take;
  logic              wr_fire;

  umu_addr_gen #(.IMM_W(IMM_W)) u_addr (
    .base      (op_base),
    .imm       (op_imm),
    .word_addr (op_word_addr),
    .shamt     (op_shamt)
  );

  umu_merge u_merge (
    .kind     (cur_kind),
    .rt_val   (cur_rt_val),
    .mem_word (mem_rsp_data),
    .shamt    (cur_shamt),
    .merged   (merged)
  );

  umu_seq #(.RIDX_W(RIDX_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_kind      (kind_e'(op_kind)),
    .op_word_addr (op_word_addr),
    .op_shamt     (op_shamt),
    .op_rt_idx    (op_rt_idx),
    .op_rt_val    (op_rt_val),
    .busy         (busy),
    .req_valid    (mem_req_valid),
    .req_ready    (mem_req_ready),
    .req_write    (mem_req_write),
    .req_addr     (mem_req_addr),
    .req_wdata    (mem_req_wdata),
    .rsp_valid    (mem_rsp_valid),
    .merged_in    (merged),
    .cur_kind     (cur_kind),
    .cur_shamt    (cur_shamt),
    .cur_rt_val   (cur_rt_val),
    .done         (done),
    .wb_valid     (wb_valid),
    .wb_idx       (wb_idx),
    .wb_data      (wb_data),
    .op_take      (op_take),
    .wr_fire      (wr_fire)
  );
endmodule

// File: rtl/umu_checker.sv
module umu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_write,
  input logic [31:0] mem_req_addr,
  input logic        done,
  input logic        wb_valid,
  input logic        op_take,
  input logic        wr_fire
);
  a_r9_req_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_wb_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> done);

  a_r9_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    op_take |=> busy);

  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r7_write_then_finish: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (done && !wb_valid));
endmodule

bind unaligned_merge_unit umu_checker u_umu_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .done          (done),
  .wb_valid      (wb_valid),
  .op_take       (op_take),
  .wr_fire       (wr_fire)
);

// File: tb/test_unaligned_merge_unit.sv
module test_unaligned_merge_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic [31:0] op_base = '0;
  logic [15:0] op_imm = '0;
  logic [4:0]  op_rt_idx = '0;
  logic [31:0] op_rt_val = '0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic        wb_valid;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  int          rd_cnt, wr_cnt;
  logic [31:0] rd_addr, wr_addr, wr_data;
  int          rsp_cnt = 0;
  logic [31:0] rsp_addr = '0;
  logic [7:0]  lfsr = 8'hA5;

  always #4 clk = ~clk;

  unaligned_merge_unit i_unaligned_merge_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_base(op_base), .op_imm(op_imm), .op_rt_idx(op_rt_idx), .op_rt_val(op_rt_val),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  // byte-lane restatement of the four merges
  function automatic logic [31:0] expect_merge(input int kind, input int k,
                                               input logic [31:0] rv,
                                               input logic [31:0] mv);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin
      case (kind)
        0: r[i*8 +: 8] = (i >= 3 - k) ? mv[(i-(3-k))*8 +: 8] : rv[i*8 +: 8];
        1: r[i*8 +: 8] = (i <= 3 - k) ? mv[(i+k)*8 +: 8]     : rv[i*8 +: 8];
        2: r[i*8 +: 8] = (i <= k)     ? rv[(i+3-k)*8 +: 8]   : mv[i*8 +: 8];
        default: r[i*8 +: 8] = (i >= k) ? rv[(i-k)*8 +: 8]   : mv[i*8 +: 8];
      endcase
    end
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: everything at the falling edge
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (rsp_cnt != 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = word_at(rsp_addr);
      end
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready = lfsr[0] | lfsr[1];
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        wr_cnt++;
        wr_addr = mem_req_addr;
        wr_data = mem_req_wdata;
      end else begin
        rd_cnt++;
        rd_addr  = mem_req_addr;
        rsp_addr = mem_req_addr;
        rsp_cnt  = 1 + int'(lfsr[3:2]);
      end
    end
  end

  task automatic run_op(input int kind, input int k, input int p,
                        input logic [31:0] base, input logic [15:0] imm,
                        input logic [4:0] idx, input logic [31:0] rv, input bit junk);
    logic [31:0] aligned, expv;
    bit          seen;
    logic        d_wbv;
    logic [4:0]  d_idx;
    logic [31:0] d_data;
    string       rq;
    aligned = (base + {{16{imm[15]}}, imm}) & 32'hFFFF_FFFC;
    expv    = expect_merge(kind, k, rv, word_at(aligned));
    while (busy) @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    op_valid = 1'b1; op_kind = 2'(kind); op_base = base; op_imm = imm;
    op_rt_idx = idx; op_rt_val = rv;
    @(negedge clk);
    check("R9", "busy after accept", 32'(busy), 32'd1);
    if (junk) begin
      op_kind = ~op_kind; op_base = ~base; op_imm = imm + 16'd5;
      op_rt_idx = ~idx; op_rt_val = ~rv;
    end else op_valid = 1'b0;
    seen = 0; d_wbv = 0; d_idx = '0; d_data = '0;
    for (int t = 0; t < 400 && !seen; t++) begin
      if (done) begin
        seen = 1; d_wbv = wb_valid; d_idx = wb_idx; d_data = wb_data;
        op_valid = 1'b0;
      end else @(negedge clk);
    end
    check("R10", "done seen", 32'(seen), 32'd1);
    @(negedge clk);
    check("R10", "done single", 32'(done), 32'd0);
    check("R9", "busy cleared", 32'(busy), 32'd0);
    check("R7", "read count", 32'(rd_cnt), 32'd1);
    check("R1", "read address", rd_addr, aligned);
    if ((kind == 0 && k == 3) || (kind == 1 && k == 0) ||
        (kind == 2 && k == 3) || (kind == 3 && k == 0))
      rq = "R11";
    else if (junk) rq = "R6";
    else case (kind)
      0: rq = "R2";
      1: rq = "R3";
      2: rq = "R4";
      default: rq = "R5";
    endcase
    if (kind >= 2) begin
      check("R7", "write count", 32'(wr_cnt), 32'd1);
      check("R7", "write address", wr_addr, aligned);
      check(rq, "store word", wr_data, expv);
      check("R10", "no wb on store", 32'(d_wbv), 32'd0);
    end else begin
      check("R7", "no write on load", 32'(wr_cnt), 32'd0);
      check("R10", "wb valid", 32'(d_wbv), 32'd1);
      check("R10", "wb index", 32'(d_idx), 32'(idx));
      check(rq, "load word", d_data, expv);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] imm_tab [3];
    imm_tab[0] = 16'h0004; imm_tab[1] = 16'hFFF8; imm_tab[2] = 16'h7FFC;
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "busy in reset", 32'(busy), 32'd0);
    check("R12", "req in reset", 32'(mem_req_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", "done after reset", 32'(done), 32'd0);
    check("R12", "wb after reset", 32'(wb_valid), 32'd0);
    for (int kind = 0; kind < 4; kind++)
      for (int k = 0; k < 4; k++)
        for (int p = 0; p < 3; p++) begin
          logic [31:0] target, base, rv;
          target = 32'h0040_1000 + 32'(p) * 32'h104 + 32'(k);
          base   = target - {{16{imm_tab[p][15]}}, imm_tab[p]};
          rv     = (32'h1122_3344 * 32'(p + 1)) ^ {8'(kind), 8'(k), 16'hC3D4};
          run_op(kind, k, p, base, imm_tab[p], 5'(kind * 8 + k * 2 + p), rv, p == 1);
        end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule